// File: doc/BRIEF.md
# Multi-core interrupt claim distributor

This block routes three classes of interrupt to several cores and settles who may take each one. Software-raised and per-core private interrupts exist once for each core. Every core acknowledges, finishes and releases its own copy of these without affecting any other core. Shared interrupts come from outside the core group. A shared interrupt may go to any core in its target set, and the first core to acknowledge it becomes its only owner. The block masks a claimed shared interrupt from every other core until the owner releases it. This holds when a level-sensitive line is still held high, because clearing a pending bit alone would not hide it.

Each core drives a small register port with three operations: an acknowledge read, an end-of-interrupt write and a deactivate write. The acknowledge read returns the lowest-numbered interrupt that core may take. If there is none, it returns the spurious code 1023. An interrupt becomes inactive again only after its owner writes its ID to end-of-interrupt and then to deactivate. From reset, the class of an ID fixes how it is claimed, so shared IDs are single-owner without any setup.

Top module: `irq_claim_dist`

## Requirements
- R1: With the default parameters, IDs 8 to 23 are shared and are single-owner from reset. After one core acknowledges such an ID, any other core that acknowledges receives 1023 and sees no `cpu_irq` for that ID until the owner deactivates it. This holds even while the ID's line stays high.
- R2: Several cores may acknowledge the same shared ID in the same cycle. The core with the lowest index receives the ID and each of the others receives 1023.
- R3: IDs 0 to 3 are software-raised (bit c*4+i of `sgi_raise` raises ID i for core c). IDs 4 to 7 are private per-core lines (bit c*4+p of `ppi_line` is ID 4+p for core c). Each core acknowledges its own copy of these IDs independently of the other cores. A software-raised pending bit clears when that core acknowledges it.
- R4: An acknowledge read that finds no interrupt the core may take returns 1023.
- R5: `cpu_irq[c]` is high exactly when core c has at least one pending, enabled, inactive interrupt that targets it. An acknowledge returns the lowest such ID.
- R6: An end-of-interrupt write alone leaves the interrupt active. A later deactivate write by the same core makes it inactive, and it can then be taken again while its level line is still high.
- R7: End-of-interrupt or deactivate writes from a core that does not own the interrupt have no effect. A deactivate that comes before the owner's end-of-interrupt also has no effect.
- R8: Shared IDs 16 to 23 are edge-triggered. They become pending on a rising edge of their line and the acknowledge clears the pending state, so a line that stays high is not taken a second time.
- R9: Shared IDs 8 to 15 are level-sensitive. Their pending state follows the line, so an ID whose line drops before the acknowledge is not returned.
- R10: An ID whose `irq_enable` bit is low is never returned. A shared ID s is never returned to core c when bit s*4+c of `spi_target` is low.
- R11: A read raises `cpu_rvalid` one cycle later, with the result on `cpu_rdata`. The acknowledge is at offset 0x00C, end-of-interrupt at 0x010 and deactivate at 0x1000. A read at any other offset returns 0 and claims nothing, and a write at any other offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sgi_raise | input | NUM_CORES*NUM_SGI | One-cycle pulses raising a software interrupt for one core |
| ppi_line | input | NUM_CORES*NUM_PPI | Level lines of the private per-core interrupts |
| spi_line | input | NUM_SPI | Lines of the shared interrupts |
| spi_target | input | NUM_SPI*NUM_CORES | Target core set of each shared interrupt |
| irq_enable | input | NUM_IDS | Enable bit for each interrupt ID |
| cpu_req | input | NUM_CORES | Register access strobe for each core |
| cpu_we | input | NUM_CORES | Write (1) or read (0) for each core |
| cpu_addr | input | NUM_CORES*13 | Register offset for each core |
| cpu_wdata | input | NUM_CORES*10 | Interrupt ID written for each core |
| cpu_rvalid | output | NUM_CORES | Read response valid for each core |
| cpu_rdata | output | NUM_CORES*10 | Read response for each core |
| cpu_irq | output | NUM_CORES | Interrupt request to each core |

## Verification
The hardest condition to reach from the ports is a shared level line held high while one core owns its interrupt and other cores keep acknowledging. A clear-pending scheme would hand the interrupt out again in exactly this case. Directed steps hold the line high through the whole end-of-interrupt and deactivate sequence, with writes from the wrong core and in the wrong order mixed in. The constrained random phase has several cores acknowledge in the same cycle, so that claims collide on a shared ID. It also routes end-of-interrupt and deactivate writes mostly to the ID each core last received, so interrupts pass through all three states many times.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int ID_W   = 10;
   localparam int ADDR_W = 13;
   localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
   localparam logic [ADDR_W-1:0] OFS_ACK     = 13'h00C;
   localparam logic [ADDR_W-1:0] OFS_EOI     = 13'h010;
   localparam logic [ADDR_W-1:0] OFS_DEACT   = 13'h1000;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACTIVE  = 2'd1,
      ST_DROPPED = 2'd2
   } act_state_e;
endpackage

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   // scanning downward leaves the lowest set bit as the result
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irqd_src.sv
// One shared source: pending capture, single-owner claim state.
module irqd_src
   import irqd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter bit LEVEL     = 1'b1,
   localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line,
   input  logic                 enable,
   input  logic [NUM_CORES-1:0] target,
   input  logic [NUM_CORES-1:0] grant,
   input  logic [NUM_CORES-1:0] eoi,
   input  logic [NUM_CORES-1:0] deact,
   output logic [NUM_CORES-1:0] cand
);
   act_state_e    st_q;
   logic [CW-1:0] owner_q;
   logic [CW-1:0] grant_idx;
   logic          pend;

   generate
      if (LEVEL) begin : g_level
         assign pend = line;
      end else begin : g_edge
         logic line_q;
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               line_q <= line;
               pend_q <= (pend_q & ~(|grant)) | (line & ~line_q);
            end
         end
         assign pend = pend_q;
      end
   endgenerate

   always_comb begin
      grant_idx = '0;
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
         if (grant[c]) grant_idx = CW'(c);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         owner_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (|grant) begin
                  st_q    <= ST_ACTIVE;
                  owner_q <= grant_idx;
               end
            end
            ST_ACTIVE:  if (eoi[owner_q])   st_q <= ST_DROPPED;
            ST_DROPPED: if (deact[owner_q]) st_q <= ST_IDLE;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   assign cand = (pend && enable && st_q == ST_IDLE) ? target : '0;

   AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_CLAIM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> (st_q == ST_IDLE)); // R1
   AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACTIVE && !eoi[owner_q]) |=> (st_q == ST_ACTIVE)); // R7
   AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> (st_q == ST_IDLE || $stable(owner_q))); // R1
endmodule

// File: rtl/irqd_local.sv
// Per-core copies of software-raised and private interrupts.
module irqd_local
   import irqd_pkg::*;
#(
   parameter int NUM_SGI = 4,
   parameter int NUM_PPI = 4,
   localparam int NL = NUM_SGI + NUM_PPI
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SGI-1:0] sgi_raise,
   input  logic [NUM_PPI-1:0] ppi_line,
   input  logic [NL-1:0]      enable,
   input  logic [NL-1:0]      grant,
   input  logic [NL-1:0]      eoi,
   input  logic [NL-1:0]      deact,
   output logic [NL-1:0]      cand
);
   for (genvar i = 0; i < NL; i++) begin : g_id
      act_state_e st_q;
      logic       pend;

      if (i < NUM_SGI) begin : g_sgi
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= (pend_q & ~grant[i]) | sgi_raise[i];
         end
         assign pend = pend_q;

         AST_SGI_GRANT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> pend_q); // R3
      end else begin : g_ppi
         assign pend = ppi_line[i-NUM_SGI];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE:    if (grant[i]) st_q <= ST_ACTIVE;
               ST_ACTIVE:  if (eoi[i])   st_q <= ST_DROPPED;
               ST_DROPPED: if (deact[i]) st_q <= ST_IDLE;
               default:    st_q <= ST_IDLE;
            endcase
         end
      end

      assign cand[i] = pend & enable[i] & (st_q == ST_IDLE);

      AST_LOCAL_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> (st_q == ST_IDLE)); // R3
   end
endmodule

// File: rtl/irq_claim_dist.sv
module irq_claim_dist
   import irqd_pkg::*;
#(
   parameter int          NUM_CORES = 4,
   parameter int          NUM_SGI   = 4,
   parameter int          NUM_PPI   = 4,
   parameter int          NUM_SPI   = 16,
   parameter logic [63:0] SPI_LEVEL = 64'h0000_0000_0000_00FF,
   localparam int NUM_LOC = NUM_SGI + NUM_PPI,
   localparam int NUM_IDS = NUM_LOC + NUM_SPI,
   localparam int IDX_W   = $clog2(NUM_IDS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CORES*NUM_SGI-1:0]   sgi_raise,
   input  logic [NUM_CORES*NUM_PPI-1:0]   ppi_line,
   input  logic [NUM_SPI-1:0]             spi_line,
   input  logic [NUM_SPI*NUM_CORES-1:0]   spi_target,
   input  logic [NUM_IDS-1:0]             irq_enable,
   input  logic [NUM_CORES-1:0]           cpu_req,
   input  logic [NUM_CORES-1:0]           cpu_we,
   input  logic [NUM_CORES*ADDR_W-1:0]    cpu_addr,
   input  logic [NUM_CORES*ID_W-1:0]      cpu_wdata,
   output logic [NUM_CORES-1:0]           cpu_rvalid,
   output logic [NUM_CORES*ID_W-1:0]      cpu_rdata,
   output logic [NUM_CORES-1:0]           cpu_irq
);
   // elaboration-time parameter checks
   if (NUM_CORES < 1 || NUM_SGI < 1 || NUM_PPI < 1 || NUM_SPI < 1) begin : g_bad_counts
      $error("irq_claim_dist: every class needs at least one entry");
   end
   if (NUM_SPI > 64) begin : g_bad_spi
      $error("irq_claim_dist: SPI_LEVEL covers at most 64 shared sources");
   end
   if (NUM_IDS > 1020) begin : g_bad_ids
      $error("irq_claim_dist: ID space collides with the spurious code");
   end

   logic [NUM_CORES-1:0] op_ack, op_eoi, op_deact, op_read;
   logic [ID_W-1:0]      wid      [NUM_CORES];
   logic [NUM_IDS-1:0]   cand_all [NUM_CORES];
   logic [NUM_LOC-1:0]   loc_cand [NUM_CORES];
   logic [NUM_CORES-1:0] spi_cand [NUM_SPI];
   logic [NUM_CORES-1:0] found, lost, gnt_ok;
   logic [IDX_W-1:0]     pick_idx [NUM_CORES];
   logic [NUM_CORES-1:0] rvalid_q;
   logic [ID_W-1:0]      rdata_q  [NUM_CORES];

   // ---------------- register port decode ----------------
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
      logic [ADDR_W-1:0] a;
      assign a           = cpu_addr[c*ADDR_W +: ADDR_W];
      assign wid[c]      = cpu_wdata[c*ID_W +: ID_W];
      assign op_read[c]  = cpu_req[c] & ~cpu_we[c];
      assign op_ack[c]   = op_read[c] & (a == OFS_ACK);
      assign op_eoi[c]   = cpu_req[c] & cpu_we[c] & (a == OFS_EOI);
      assign op_deact[c] = cpu_req[c] & cpu_we[c] & (a == OFS_DEACT);
   end

   // ---------------- claim arbitration ----------------
   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         lost[c] = 1'b0;
         for (int d = 0; d < NUM_CORES; d++) begin
            if (d < c && op_ack[d] && found[d] && found[c] &&
                pick_idx[d] == pick_idx[c] && pick_idx[c] >= IDX_W'(NUM_LOC))
               lost[c] = 1'b1;
         end
         gnt_ok[c] = op_ack[c] & found[c] & ~lost[c];
      end
   end

   // ---------------- per-core local state and selection ----------------
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [NUM_LOC-1:0] l_gnt, l_eoi, l_deact;

      for (genvar i = 0; i < NUM_LOC; i++) begin : g_lsel
         assign l_gnt[i]   = gnt_ok[c] & (pick_idx[c] == IDX_W'(i));
         assign l_eoi[i]   = op_eoi[c] & (wid[c] == ID_W'(i));
         assign l_deact[i] = op_deact[c] & (wid[c] == ID_W'(i));
      end

      irqd_local #(
         .NUM_SGI (NUM_SGI),
         .NUM_PPI (NUM_PPI)
      ) i_local (
         .clk       (clk),
         .rst_n     (rst_n),
         .sgi_raise (sgi_raise[c*NUM_SGI +: NUM_SGI]),
         .ppi_line  (ppi_line[c*NUM_PPI +: NUM_PPI]),
         .enable    (irq_enable[NUM_LOC-1:0]),
         .grant     (l_gnt),
         .eoi       (l_eoi),
         .deact     (l_deact),
         .cand      (loc_cand[c])
      );

      always_comb begin
         cand_all[c][NUM_LOC-1:0] = loc_cand[c];
         for (int s = 0; s < NUM_SPI; s++) cand_all[c][NUM_LOC+s] = spi_cand[s][c];
      end

      irqd_pick #(
         .N (NUM_IDS)
      ) i_pick (
         .vec   (cand_all[c]),
         .found (found[c]),
         .idx   (pick_idx[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rvalid_q[c] <= 1'b0;
            rdata_q[c]  <= '0;
         end else begin
            rvalid_q[c] <= op_read[c];
            if (op_ack[c])       rdata_q[c] <= gnt_ok[c] ? ID_W'(pick_idx[c]) : SPURIOUS_ID;
            else if (op_read[c]) rdata_q[c] <= '0;
         end
      end

      assign cpu_rvalid[c]               = rvalid_q[c];
      assign cpu_rdata[c*ID_W +: ID_W]   = rdata_q[c];
      assign cpu_irq[c]                  = found[c];

      AST_SPURIOUS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (op_ack[c] && !cpu_irq[c]) |=> (cpu_rdata[c*ID_W +: ID_W] == SPURIOUS_ID)); // R4
      AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
         op_read[c] |=> cpu_rvalid[c]); // R11
   end

   // ---------------- shared sources ----------------
   for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
      logic [NUM_CORES-1:0] s_gnt, s_eoi, s_deact;
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_ssel
         assign s_gnt[c]   = gnt_ok[c] & (pick_idx[c] == IDX_W'(NUM_LOC + s));
         assign s_eoi[c]   = op_eoi[c] & (wid[c] == ID_W'(NUM_LOC + s));
         assign s_deact[c] = op_deact[c] & (wid[c] == ID_W'(NUM_LOC + s));
      end

      irqd_src #(
         .NUM_CORES (NUM_CORES),
         .LEVEL     (SPI_LEVEL[s])
      ) i_src (
         .clk    (clk),
         .rst_n  (rst_n),
         .line   (spi_line[s]),
         .enable (irq_enable[NUM_LOC+s]),
         .target (spi_target[s*NUM_CORES +: NUM_CORES]),
         .grant  (s_gnt),
         .eoi    (s_eoi),
         .deact  (s_deact),
         .cand   (spi_cand[s])
      );
   end

   AST_CORE0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ack[0] && cpu_irq[0]) |=> (cpu_rdata[ID_W-1:0] != SPURIOUS_ID)); // R2
endmodule

// File: tb/test_irq_claim_dist.sv
module test_irq_claim_dist;
   localparam int NC = 4, NS = 4, NP = 4, NSPI = 16;
   localparam int NL = NS + NP, NID = NL + NSPI;
   localparam logic [15:0] LVL = 16'h00FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NC*NS-1:0]   sgi_raise = '0;
   logic [NC*NP-1:0]   ppi_line = '0;
   logic [NSPI-1:0]    spi_line = '0;
   logic [NSPI*NC-1:0] spi_target = '1;
   logic [NID-1:0]     irq_enable = '1;
   logic [NC-1:0]      cpu_req = '0, cpu_we = '0;
   logic [NC*13-1:0]   cpu_addr = '0;
   logic [NC*10-1:0]   cpu_wdata = '0;
   logic [NC-1:0]      cpu_rvalid, cpu_irq;
   logic [NC*10-1:0]   cpu_rdata;

   irq_claim_dist i_irq_claim_dist (
      .clk(clk), .rst_n(rst_n), .sgi_raise(sgi_raise), .ppi_line(ppi_line),
      .spi_line(spi_line), .spi_target(spi_target), .irq_enable(irq_enable),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq));

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model: 0 idle, 1 active, 2 dropped
   int  m_loc [NC][NL];
   bit  m_sgi [NC][NS];
   int  m_spi [NSPI];
   int  m_own [NSPI];
   bit  m_ep  [NSPI];
   bit  l_prev[NSPI];
   int  kind[NC], kid[NC], last_id[NC];
   int  e_rd[NC];
   bit  e_rv[NC];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_cand(int c, int id);
      int s;
      if (!irq_enable[id]) return 0;
      if (id < NS) return m_sgi[c][id] && m_loc[c][id] == 0;
      if (id < NL) return ppi_line[c*NP+id-NS] && m_loc[c][id] == 0;
      s = id - NL;
      return spi_target[s*NC+c] && m_spi[s] == 0 && (LVL[s] ? spi_line[s] : m_ep[s]);
   endfunction

   function automatic int m_pick(int c);
      for (int id = 0; id < NID; id++) if (m_cand(c, id)) return id;
      return 1023;
   endfunction

   // kinds: 0 none, 1 ack, 2 eoi, 3 deact, 4 read elsewhere, 5 write elsewhere
   task automatic set_op(int c, int k, int id);
      kind[c] = k; kid[c] = id;
      cpu_req[c] = (k != 0);
      cpu_we[c]  = (k == 2 || k == 3 || k == 5);
      cpu_addr[c*13 +: 13] = (k == 1) ? 13'h00C : (k == 2) ? 13'h010 :
                             (k == 3) ? 13'h1000 : (k == 4) ? 13'h010 : 13'h014;
      cpu_wdata[c*10 +: 10] = 10'(id);
   endtask

   task automatic cyc();
      int pk[NC];
      bit g[NC];
      bit spi_g[NSPI];
      for (int s = 0; s < NSPI; s++) spi_g[s] = 0;
      for (int c = 0; c < NC; c++) begin
         pk[c] = m_pick(c); g[c] = 0;
         e_rv[c] = (kind[c] == 1 || kind[c] == 4);
         e_rd[c] = 0;
         if (kind[c] == 1) begin
            g[c] = (pk[c] != 1023);
            if (g[c] && pk[c] >= NL)
               for (int d = 0; d < c; d++) if (kind[d] == 1 && pk[d] == pk[c]) g[c] = 0;
            e_rd[c] = g[c] ? pk[c] : 1023;
            if (g[c]) last_id[c] = pk[c];
         end
      end
      for (int c = 0; c < NC; c++) begin
         int k = kid[c];
         if ((kind[c] == 2 || kind[c] == 3) && k < NID) begin
            if (k < NL) begin
               if (kind[c] == 2 && m_loc[c][k] == 1) m_loc[c][k] = 2;
               else if (kind[c] == 3 && m_loc[c][k] == 2) m_loc[c][k] = 0;
            end else if (m_own[k-NL] == c) begin
               if (kind[c] == 2 && m_spi[k-NL] == 1) m_spi[k-NL] = 2;
               else if (kind[c] == 3 && m_spi[k-NL] == 2) m_spi[k-NL] = 0;
            end
         end
      end
      for (int c = 0; c < NC; c++) if (g[c]) begin
         if (pk[c] < NL) begin
            m_loc[c][pk[c]] = 1;
            if (pk[c] < NS) m_sgi[c][pk[c]] = 0;
         end else begin
            m_spi[pk[c]-NL] = 1; m_own[pk[c]-NL] = c; spi_g[pk[c]-NL] = 1;
         end
      end
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NS; i++) if (sgi_raise[c*NS+i]) m_sgi[c][i] = 1;
      for (int s = 0; s < NSPI; s++) begin
         m_ep[s] = (m_ep[s] & !spi_g[s]) | (spi_line[s] & !l_prev[s]);
         l_prev[s] = spi_line[s];
      end
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         chk("R11 rvalid", int'(cpu_rvalid[c]), int'(e_rv[c]));
         if (e_rv[c]) chk("R1 R4 read data", int'(cpu_rdata[c*10 +: 10]), e_rd[c]);
         chk("R5 cpu_irq", int'(cpu_irq[c]), int'(m_pick(c) != 1023));
      end
      for (int c = 0; c < NC; c++) set_op(c, 0, 0);
      sgi_raise = '0;
   endtask

   task automatic ack1(int c, int exp, string tag);
      set_op(c, 1, 0);
      cyc();
      chk(tag, int'(cpu_rdata[c*10 +: 10]), exp);
   endtask

   task automatic release1(int c, int id);
      set_op(c, 2, id); cyc();
      set_op(c, 3, id); cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         kind[c] = 0; kid[c] = 0; last_id[c] = 0;
         for (int i = 0; i < NL; i++) m_loc[c][i] = 0;
         for (int i = 0; i < NS; i++) m_sgi[c][i] = 0;
      end
      for (int s = 0; s < NSPI; s++) begin
         m_spi[s] = 0; m_own[s] = 0; m_ep[s] = 0; l_prev[s] = 0;
      end
      repeat (3) @(negedge clk);
      chk("reset cpu_irq", int'(cpu_irq), 0);
      chk("reset cpu_rvalid", int'(cpu_rvalid), 0);
      rst_n = 1'b1;
      cyc();

      // R4: nothing pending
      ack1(0, 1023, "R4 empty ack");

      // R1: level shared ID 8 stays claimed while line high
      spi_line[0] = 1'b1; cyc();
      ack1(1, 8, "R1 first claim");
      ack1(0, 1023, "R1 other core blocked");
      chk("R1 no irq on other core", int'(cpu_irq[0]), 0);
      // R7: non-owner EOI, deactivate before EOI
      set_op(0, 2, 8); cyc();
      set_op(1, 3, 8); cyc();
      set_op(1, 2, 8); cyc();
      ack1(0, 1023, "R6 EOI alone keeps active");
      set_op(0, 3, 8); cyc();
      ack1(2, 1023, "R7 non-owner deactivate ignored");
      set_op(1, 3, 8); cyc();
      ack1(2, 8, "R6 retaken after deactivate");
      release1(2, 8);
      spi_line[0] = 1'b0; cyc();

      // R2: same-cycle claims
      spi_line[1] = 1'b1; cyc();
      set_op(1, 1, 0); set_op(2, 1, 0); set_op(3, 1, 0);
      cyc();
      chk("R2 core1 wins", int'(cpu_rdata[10 +: 10]), 9);
      chk("R2 core2 loses", int'(cpu_rdata[20 +: 10]), 1023);
      chk("R2 core3 loses", int'(cpu_rdata[30 +: 10]), 1023);
      release1(1, 9);
      spi_line[1] = 1'b0; cyc();

      // R3: per-core copies
      ppi_line[0] = 1'b1; ppi_line[4] = 1'b1; cyc();
      set_op(0, 1, 0); set_op(1, 1, 0);
      cyc();
      chk("R3 core0 private", int'(cpu_rdata[0 +: 10]), 4);
      chk("R3 core1 private", int'(cpu_rdata[10 +: 10]), 4);
      sgi_raise[2*NS+1] = 1'b1; cyc();
      ack1(2, 1, "R3 software raise");
      ack1(2, 1023, "R3 software pending cleared");
      release1(0, 4); release1(1, 4); release1(2, 1);
      ppi_line = '0; cyc();

      // R5: lowest ID first
      ppi_line[3*NP+1] = 1'b1; spi_line[3] = 1'b1; cyc();
      chk("R5 irq raised", int'(cpu_irq[3]), 1);
      ack1(3, 5, "R5 lowest first");
      ack1(3, 11, "R5 next lowest");
      chk("R5 irq cleared", int'(cpu_irq[3]), 0);
      release1(3, 5); release1(3, 11);
      ppi_line = '0; spi_line[3] = 1'b0; cyc();

      // R8: edge shared ID 16
      spi_line[8] = 1'b1; cyc();
      ack1(0, 16, "R8 edge claim");
      release1(0, 16);
      ack1(1, 1023, "R8 held line not repended");
      spi_line[8] = 1'b0; cyc();
      spi_line[8] = 1'b1; cyc();
      ack1(1, 16, "R8 new edge");
      release1(1, 16);
      spi_line[8] = 1'b0; cyc();

      // R9: level drops before ack
      spi_line[4] = 1'b1; cyc();
      chk("R9 irq while high", int'(cpu_irq[0]), 1);
      spi_line[4] = 1'b0;
      ack1(0, 1023, "R9 dropped level");

      // R10: enable and target
      irq_enable[13] = 1'b0; spi_line[5] = 1'b1; cyc();
      ack1(0, 1023, "R10 disabled");
      irq_enable[13] = 1'b1; spi_target[5*NC+0] = 1'b0; cyc();
      ack1(0, 1023, "R10 not targeted");
      ack1(1, 13, "R10 targeted core");
      release1(1, 13);
      spi_line[5] = 1'b0; spi_target = '1; cyc();

      // R11: other offsets
      set_op(0, 4, 0); cyc();
      chk("R11 other read data", int'(cpu_rdata[0 +: 10]), 0);
      spi_line[2] = 1'b1; cyc();
      ack1(0, 10, "R11 claim");
      set_op(0, 5, 10); cyc();
      set_op(0, 5, 10); cyc();
      set_op(0, 3, 10); cyc();
      ack1(1, 1023, "R11 other write ignored");
      cyc();
      chk("R11 rvalid low after idle", int'(cpu_rvalid[0]), 0);
      release1(0, 10);
      spi_line[2] = 1'b0; cyc();

      // constrained random phase
      void'($urandom(32'h1CE5));
      for (int s = 0; s < NSPI; s++)
         for (int c = 0; c < NC; c++) spi_target[s*NC+c] = ($urandom % 4) != 0;
      for (int n = 0; n < 4000; n++) begin
         for (int s = 0; s < NSPI; s++) if ($urandom % 8 == 0) spi_line[s] = ~spi_line[s];
         for (int b = 0; b < NC*NP; b++) if ($urandom % 10 == 0) ppi_line[b] = ~ppi_line[b];
         for (int b = 0; b < NC*NS; b++) sgi_raise[b] = ($urandom % 16 == 0);
         for (int c = 0; c < NC; c++) begin
            int r = $urandom % 20;
            int id = ($urandom % 4 != 0) ? last_id[c] : int'($urandom % NID);
            if (r < 7)       set_op(c, 0, 0);
            else if (r < 13) set_op(c, 1, 0);
            else if (r < 16) set_op(c, 2, id);
            else if (r < 19) set_op(c, 3, id);
            else             set_op(c, 4 + int'($urandom % 2), id);
         end
         cyc();
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule